// File: doc/BRIEF.md
# Parallel Display Bus Master (8-bit, strobed read/write)

This block sits on the host side of an 8-bit parallel display link that uses separate active-low write and read strobes, an active-low chip select and a register-select line. Logic inside the chip hands it one 16-bit command at a time over a valid/ready port. The command is an index write, a register write, a register read or a RAM data write. The block splits the word into two bytes and moves each byte in its own strobe cycle. For reads, it assembles the two returned bytes into a word and reports it on a one-cycle response pulse.

Every bus phase is held for a whole number of system clock cycles. These counts come from nanosecond minimums and the clock period, which are all parameters, and each count is rounded up. There are three timing profiles: normal write, fast write and read. The fast profile shortens the write cycle and the strobe-high time. It is used only when the fast-write input is set and the command is a RAM data write. The data bus is split into output, output-enable and input, so that the pad ring can build the tri-state driver.

Top module: `lcd8080_master`

## Requirements
- R1: The command kind is encoded as 00 index write, 01 register write, 10 register read and 11 RAM data write. The register-select line is low for index writes and high for the other three kinds. It does not change while chip select is low.
- R2: Chip select, the write strobe and the read strobe are active low and are all high when idle. A write command pulses only the write strobe and a read command pulses only the read strobe. A strobe is low only while chip select is low.
- R3: With a 4 ns clock, a normal-profile write holds the write strobe low for 15 cycles (the larger of the 40 ns pulse and the 60 ns data setup). It holds the strobe high for 35 cycles between the two bytes, giving a 200 ns byte cycle.
- R4: Chip select falls and register select settles 3 cycles (10 ns) before the first strobe falls. After the last strobe rises, chip select stays low for the profile's high time (35 normal write, 10 fast write, 25 read).
- R5: A read holds the read strobe low for 50 cycles (the larger of the 150 ns pulse and the 200 ns data delay) and high for 25 cycles between bytes. Each byte is sampled at the clock edge where the read strobe rises, so data that becomes valid only after 200 ns is still captured.
- R6: A RAM data write with the fast-write input high holds the strobe low for 15 cycles and high for 10 cycles, giving a 100 ns byte cycle.
- R7: The fast-write input has no effect on index writes, register writes or reads. These always use their normal profile.
- R8: The upper byte is transferred first and the lower byte second, for both writes and reads. Write data is placed on the bus no later than the strobe fall and stays unchanged while the strobe is low.
- R9: The bus output enable is high only during a write transaction and is never high while the read strobe is low.
- R10: The ready output is high only when the bus is idle. Each accepted command produces exactly one bus transaction. A read ends with a single-cycle response pulse carrying the assembled word, in the cycle in which chip select rises. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted on this cycle if valid |
| cmd_kind | input | 2 | Command kind (see R1) |
| cmd_wdata | input | 16 | Word to write (index value, register or RAM data) |
| hs_mode | input | 1 | Fast-write request, honoured for RAM data writes only |
| rsp_valid | output | 1 | One-cycle pulse at the end of a read |
| rsp_data | output | 16 | Assembled read word |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select: low for index, high for data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_db_o | output | 8 | Data bus output value |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_i | input | 8 | Data bus input value |

## Verification
The bench measures every strobe-low width, the high gap between bytes, the chip-select lead and the tail in whole cycles, and compares each with counts it derives from the nanosecond minimums. An off-by-one in any phase counter therefore shows up as a wrong width. A panel model drives a wrong pattern on the data lines until exactly 200 ns after the read strobe falls, so a design that samples one cycle early returns a corrupted word. RAM writes are run with the fast input set and clear, and the other write kinds are run with it set. A design that applied the fast profile too widely would show a 10-cycle gap where 35 cycles are expected. Byte order, register-select level and stability, and output enable during reads are checked on every transaction.

// File: rtl/lcd8080_pkg.sv
`timescale 1ns/1ps
package lcd8080_pkg;

  typedef enum logic [1:0] {
    CMD_INDEX_WR = 2'b00,
    CMD_REG_WR   = 2'b01,
    CMD_REG_RD   = 2'b10,
    CMD_RAM_WR   = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    PROF_WR_NORM = 2'd0,
    PROF_WR_FAST = 2'd1,
    PROF_RD      = 2'd2
  } prof_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd8080_phase_len.sv
`timescale 1ns/1ps
module lcd8080_phase_len
  import lcd8080_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int N_WL       = 15,
  parameter int N_WH       = 35,
  parameter int N_WHF      = 10,
  parameter int N_RL       = 50,
  parameter int N_RH       = 25,
  parameter int HS_SUPPORT = 1
) (
  input  prof_e             prof,
  output logic [CNT_W-1:0]  low_len,
  output logic [CNT_W-1:0]  high_len
);

  logic [CNT_W-1:0] fast_high;

  generate
    if (HS_SUPPORT != 0) begin : g_fast
      assign fast_high = CNT_W'(N_WHF);
    end else begin : g_nofast
      assign fast_high = CNT_W'(N_WH);
    end
  endgenerate

  always_comb begin
    unique case (prof)
      PROF_RD: begin
        low_len  = CNT_W'(N_RL);
        high_len = CNT_W'(N_RH);
      end
      PROF_WR_FAST: begin
        low_len  = CNT_W'(N_WL);
        high_len = fast_high;
      end
      default: begin
        low_len  = CNT_W'(N_WL);
        high_len = CNT_W'(N_WH);
      end
    endcase
  end

endmodule

// File: rtl/lcd8080_phase_timer.sv
`timescale 1ns/1ps
module lcd8080_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = load_val - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R3: an expired timer stays expired until reloaded
  p_timer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

  // R3: a load of N makes the phase last N cycles (not yet done after one)
  p_timer_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > CNT_W'(1)) |=> !done);

endmodule

// File: rtl/lcd8080_rd_assemble.sv
`timescale 1ns/1ps
module lcd8080_rd_assemble #(
  parameter int BUS_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BUS_W-1:0]  din,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] word_q, word_d;

  // earlier bytes move toward the top: first byte ends up most significant
  always_comb begin
    word_d = word_q;
    if (cap_en)
      word_d = {word_q[WORD_W-BUS_W-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

endmodule

// File: rtl/lcd8080_master.sv
`timescale 1ns/1ps
module lcd8080_master
  import lcd8080_pkg::*;
#(
  parameter int CLK_PS       = 4000,
  parameter int BUS_W        = 8,
  parameter int WORD_W       = 16,
  parameter int HS_SUPPORT   = 1,
  parameter int T_AS_NS      = 10,
  parameter int T_AH_NS      = 2,
  parameter int T_DH_NS      = 2,
  parameter int T_DSW_NS     = 60,
  parameter int T_WL_NS      = 40,
  parameter int T_WH_NS      = 100,
  parameter int T_WCYC_NS    = 200,
  parameter int T_WH_HS_NS   = 40,
  parameter int T_WCYC_HS_NS = 100,
  parameter int T_RL_NS      = 150,
  parameter int T_RH_NS      = 100,
  parameter int T_RCYC_NS    = 300,
  parameter int T_RDD_NS     = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              hs_mode,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              lcd_cs_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [BUS_W-1:0]  lcd_db_o,
  output logic              lcd_db_oe,
  input  logic [BUS_W-1:0]  lcd_db_i
);

  // ---------------- derived cycle counts ----------------
  localparam int N_SU   = imax(1, ns2cyc(T_AS_NS, CLK_PS));
  localparam int N_HOLD = imax(1, imax(ns2cyc(T_AH_NS, CLK_PS), ns2cyc(T_DH_NS, CLK_PS)));
  localparam int N_HMIN = imax(N_HOLD, N_SU);
  localparam int N_WL   = imax(1, imax(ns2cyc(T_WL_NS, CLK_PS), ns2cyc(T_DSW_NS, CLK_PS)));
  localparam int N_WH   = imax(N_HMIN, imax(ns2cyc(T_WH_NS, CLK_PS),
                                            ns2cyc(T_WCYC_NS, CLK_PS) - N_WL));
  localparam int N_WHF  = imax(N_HMIN, imax(ns2cyc(T_WH_HS_NS, CLK_PS),
                                            ns2cyc(T_WCYC_HS_NS, CLK_PS) - N_WL));
  localparam int N_RL   = imax(1, imax(ns2cyc(T_RL_NS, CLK_PS), ns2cyc(T_RDD_NS, CLK_PS)));
  localparam int N_RH   = imax(N_HMIN, imax(ns2cyc(T_RH_NS, CLK_PS),
                                            ns2cyc(T_RCYC_NS, CLK_PS) - N_RL));
  localparam int N_MAX  = imax(imax(imax(N_SU, N_WL), imax(N_WH, N_WHF)), imax(N_RL, N_RH));
  localparam int CNT_W  = $clog2(N_MAX + 1);
  localparam int NBYTES = WORD_W / BUS_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // ---------------- state ----------------
  phase_e             phase_q, phase_d;
  prof_e              prof_q, prof_d;
  logic               is_rd_q, is_rd_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               cs_n_q, cs_n_d;
  logic               wr_n_q, wr_n_d;
  logic               rd_n_q, rd_n_d;
  logic               rs_q, rs_d;
  logic [BUS_W-1:0]   db_q, db_d;
  logic               oe_q, oe_d;
  logic               rsp_q, rsp_d;

  logic               tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic               tmr_done;
  logic [CNT_W-1:0]   low_len, high_len;
  logic               cap_en;
  logic               last_byte;

  function automatic logic [BUS_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input int i);
    logic [WORD_W-1:0] s;
    s = w >> (BUS_W * (NBYTES - 1 - i));
    return s[BUS_W-1:0];
  endfunction

  lcd8080_phase_len #(
    .CNT_W(CNT_W), .N_WL(N_WL), .N_WH(N_WH), .N_WHF(N_WHF),
    .N_RL(N_RL), .N_RH(N_RH), .HS_SUPPORT(HS_SUPPORT)
  ) u_len (
    .prof     (prof_q),
    .low_len  (low_len),
    .high_len (high_len)
  );

  lcd8080_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  lcd8080_rd_assemble #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cap_en (cap_en),
    .din    (lcd_db_i),
    .word   (rsp_data)
  );

  assign last_byte = (idx_q == IDX_W'(NBYTES - 1));

  // ---------------- next-state ----------------
  always_comb begin
    phase_d  = phase_q;
    prof_d   = prof_q;
    is_rd_d  = is_rd_q;
    word_d   = word_q;
    idx_d    = idx_q;
    cs_n_d   = cs_n_q;
    wr_n_d   = wr_n_q;
    rd_n_d   = rd_n_q;
    rs_d     = rs_q;
    db_d     = db_q;
    oe_d     = oe_q;
    rsp_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;

    unique case (phase_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          phase_d  = PH_SETUP;
          is_rd_d  = (cmd_kind == CMD_REG_RD);
          rs_d     = (cmd_kind != CMD_INDEX_WR);
          if (cmd_kind == CMD_REG_RD)
            prof_d = PROF_RD;
          else if (cmd_kind == CMD_RAM_WR && hs_mode)
            prof_d = PROF_WR_FAST;
          else
            prof_d = PROF_WR_NORM;
          word_d   = cmd_wdata;
          idx_d    = '0;
          cs_n_d   = 1'b0;
          oe_d     = (cmd_kind != CMD_REG_RD);
          db_d     = pick_byte(cmd_wdata, 0);
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_SU);
        end
      end
      PH_SETUP: begin
        if (tmr_done) begin
          phase_d  = PH_LOW;
          if (is_rd_q) rd_n_d = 1'b0;
          else         wr_n_d = 1'b0;
          db_d     = pick_byte(word_q, int'(idx_q));
          tmr_load = 1'b1;
          tmr_val  = low_len;
        end
      end
      PH_LOW: begin
        if (tmr_done) begin
          phase_d  = PH_HIGH;
          wr_n_d   = 1'b1;
          rd_n_d   = 1'b1;
          cap_en   = is_rd_q;
          tmr_load = 1'b1;
          tmr_val  = high_len;
        end
      end
      default: begin
        if (tmr_done) begin
          if (!last_byte) begin
            phase_d  = PH_LOW;
            idx_d    = idx_q + IDX_W'(1);
            if (is_rd_q) rd_n_d = 1'b0;
            else         wr_n_d = 1'b0;
            db_d     = pick_byte(word_q, int'(idx_q) + 1);
            tmr_load = 1'b1;
            tmr_val  = low_len;
          end else begin
            phase_d = PH_IDLE;
            cs_n_d  = 1'b1;
            oe_d    = 1'b0;
            rsp_d   = is_rd_q;
          end
        end
      end
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_IDLE;
      prof_q  <= PROF_WR_NORM;
      is_rd_q <= 1'b0;
      word_q  <= '0;
      idx_q   <= '0;
      cs_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      rs_q    <= 1'b0;
      db_q    <= '0;
      oe_q    <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      prof_q  <= prof_d;
      is_rd_q <= is_rd_d;
      word_q  <= word_d;
      idx_q   <= idx_d;
      cs_n_q  <= cs_n_d;
      wr_n_q  <= wr_n_d;
      rd_n_q  <= rd_n_d;
      rs_q    <= rs_d;
      db_q    <= db_d;
      oe_q    <= oe_d;
      rsp_q   <= rsp_d;
    end
  end

  assign cmd_ready = (phase_q == PH_IDLE);
  assign rsp_valid = rsp_q;
  assign lcd_cs_n  = cs_n_q;
  assign lcd_rs    = rs_q;
  assign lcd_wr_n  = wr_n_q;
  assign lcd_rd_n  = rd_n_q;
  assign lcd_db_o  = db_q;
  assign lcd_db_oe = oe_q;

  // ---------------- assertions ----------------
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!lcd_wr_n && !lcd_rd_n));

  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);

  p_rs_stable_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lcd_cs_n |=> (lcd_cs_n || $stable(lcd_rs)));

  p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lcd_wr_n |=> (lcd_wr_n || $stable(lcd_db_o)));

  p_no_drive_rd_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !lcd_rd_n |-> !lcd_db_oe);

  p_oe_in_cs_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    lcd_db_oe |-> !lcd_cs_n);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_ready |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_at_end_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> $rose(lcd_cs_n));

endmodule

// File: tb/lcd8080_master_tb.sv
`timescale 1ns/1ps
module lcd8080_master_tb;

  localparam int CLK_NS = 4;

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths from the nanosecond minimums
  localparam int E_SU  = 3;
  int e_wl, e_wh, e_whf, e_rl, e_rh;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'b00;
  logic [15:0] cmd_wdata = '0;
  logic        hs_mode = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_db_oe;
  logic [7:0]  lcd_db_o;
  logic [7:0]  lcd_db_i = 8'hEE;

  always #2 clk = ~clk;

  lcd8080_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_wdata(cmd_wdata), .hs_mode(hs_mode),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_db_o(lcd_db_o), .lcd_db_oe(lcd_db_oe), .lcd_db_i(lcd_db_i)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- bus monitor and panel model (negedge sampling) ----------------
  int t = 0;
  int cs_fall_t, cs_rise_t;
  int nfall, nwr, nrd;
  int fall_t [4];
  int rise_t [4];
  logic [7:0] b_first [4];
  logic [7:0] b_last  [4];
  logic       rs_at   [4];
  int oe_low_bad = 0;
  int v_oe_rd = 0, v_rs = 0, v_oe_idle = 0;
  int rsp_cnt = 0;
  logic [15:0] rsp_last = '0;
  logic [15:0] rd_word = '0;
  int rd_k = 0;
  logic p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1, p_rs = 1'b0;

  always @(negedge clk) begin
    t++;
    if (p_cs && !lcd_cs_n) begin
      cs_fall_t = t; nfall = 0; nwr = 0; nrd = 0;
    end
    if (!p_cs && lcd_cs_n) cs_rise_t = t;
    if ((p_wr && !lcd_wr_n) || (p_rd && !lcd_rd_n)) begin
      if (nfall < 4) begin
        fall_t[nfall]  = t;
        b_first[nfall] = lcd_db_o;
        rs_at[nfall]   = lcd_rs;
      end
      if (!lcd_wr_n) nwr++;
      if (!lcd_rd_n) nrd++;
    end
    if (!lcd_wr_n) begin
      if (nfall < 4) b_last[nfall] = lcd_db_o;
      if (!lcd_db_oe) oe_low_bad++;
    end
    if ((!p_wr && lcd_wr_n) || (!p_rd && lcd_rd_n)) begin
      if (nfall < 4) rise_t[nfall] = t;
      nfall++;
    end
    if (lcd_db_oe && !lcd_rd_n) v_oe_rd++;
    if (lcd_db_oe && lcd_cs_n) v_oe_idle++;
    if (!p_cs && !lcd_cs_n && (lcd_rs != p_rs)) v_rs++;
    if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_data; end
    // panel model: wrong pattern until 200 ns after the read strobe falls
    if (!lcd_rd_n) rd_k++; else rd_k = 0;
    if (!lcd_rd_n && rd_k >= e_rl)
      lcd_db_i = (nfall == 0) ? rd_word[15:8] : rd_word[7:0];
    else
      lcd_db_i = 8'hEE;
    p_cs = lcd_cs_n; p_wr = lcd_wr_n; p_rd = lcd_rd_n; p_rs = lcd_rs;
  end

  // ---------------- command driver ----------------
  task automatic issue(input logic [1:0] k, input logic [15:0] d, input logic hs);
    while (!cmd_ready) @(negedge clk);
    cmd_kind = k; cmd_wdata = d; hs_mode = hs; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_write(input string req, input logic [15:0] d, input logic rs_exp,
                             input int lo, input int hi);
    chk(req, "write strobe count", nwr, 2);
    chk("R2", "read strobe count on write", nrd, 0);
    chk("R8", "upper byte", b_last[0], d[15:8]);
    chk("R8", "lower byte", b_last[1], d[7:0]);
    chk("R8", "byte 0 stable", b_first[0], b_last[0]);
    chk("R8", "byte 1 stable", b_first[1], b_last[1]);
    chk("R1", "rs at byte 0", rs_at[0], rs_exp);
    chk("R1", "rs at byte 1", rs_at[1], rs_exp);
    chk("R4", "cs lead", fall_t[0] - cs_fall_t, E_SU);
    chk(req, "low width byte 0", rise_t[0] - fall_t[0], lo);
    chk(req, "low width byte 1", rise_t[1] - fall_t[1], lo);
    chk(req, "high gap", fall_t[1] - rise_t[0], hi);
    chk("R4", "cs tail", cs_rise_t - rise_t[1], hi);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R2", "cs idle", lcd_cs_n, 1);
    chk("R2", "wr idle", lcd_wr_n, 1);
    chk("R2", "rd idle", lcd_rd_n, 1);
    chk("R9", "oe idle", lcd_db_oe, 0);
    chk("R10", "ready idle", cmd_ready, 1);
    chk("R10", "no response", rsp_valid, 0);
  endtask

  task automatic t_index_write();
    int r0 = rsp_cnt;
    issue(2'b00, 16'h0022, 1'b0);
    check_write("R3", 16'h0022, 1'b0, e_wl, e_wh);
    chk("R3", "byte cycle", fall_t[1] - fall_t[0], cyc(200));
    chk("R10", "no rsp on write", rsp_cnt - r0, 0);
  endtask

  task automatic t_reg_write_hs_ignored();
    issue(2'b01, 16'h1234, 1'b1);
    check_write("R7", 16'h1234, 1'b1, e_wl, e_wh);
  endtask

  task automatic t_index_write_hs_ignored();
    issue(2'b00, 16'h00F0, 1'b1);
    check_write("R7", 16'h00F0, 1'b0, e_wl, e_wh);
  endtask

  task automatic t_ram_write_fast();
    issue(2'b11, 16'hABCD, 1'b1);
    check_write("R6", 16'hABCD, 1'b1, e_wl, e_whf);
    chk("R6", "fast byte cycle", fall_t[1] - fall_t[0], cyc(100));
  endtask

  task automatic t_ram_write_normal();
    issue(2'b11, 16'h5A0F, 1'b0);
    check_write("R3", 16'h5A0F, 1'b1, e_wl, e_wh);
  endtask

  task automatic t_read(input logic [15:0] w, input logic hs);
    int r0 = rsp_cnt;
    rd_word = w;
    issue(2'b10, 16'hFFFF, hs);
    chk("R2", "read strobe count", nrd, 2);
    chk("R2", "write strobe count on read", nwr, 0);
    chk("R1", "rs on read", rs_at[0], 1);
    chk("R4", "cs lead read", fall_t[0] - cs_fall_t, E_SU);
    chk("R5", "read low byte 0", rise_t[0] - fall_t[0], e_rl);
    chk("R5", "read low byte 1", rise_t[1] - fall_t[1], e_rl);
    chk(hs ? "R7" : "R5", "read high gap", fall_t[1] - rise_t[0], e_rh);
    chk("R4", "cs tail read", cs_rise_t - rise_t[1], e_rh);
    chk("R10", "one response", rsp_cnt - r0, 1);
    chk("R5", "read word", rsp_last, w);
  endtask

  task automatic t_back_to_back();
    issue(2'b11, 16'h8001, 1'b1);
    check_write("R6", 16'h8001, 1'b1, e_wl, e_whf);
    t_read(16'h3C96, 1'b0);
    issue(2'b00, 16'h0007, 1'b0);
    check_write("R3", 16'h0007, 1'b0, e_wl, e_wh);
  endtask

  initial begin
    e_wl  = mx(cyc(40), cyc(60));
    e_wh  = mx(cyc(100), cyc(200) - e_wl);
    e_whf = mx(cyc(40), cyc(100) - e_wl);
    e_rl  = mx(cyc(150), cyc(200));
    e_rh  = mx(cyc(100), cyc(300) - e_rl);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_index_write();
    t_reg_write_hs_ignored();
    t_index_write_hs_ignored();
    t_ram_write_fast();
    t_ram_write_normal();
    t_read(16'h0766, 1'b0);
    t_read(16'hA55A, 1'b1);
    t_back_to_back();
    chk("R9", "oe during read strobe", v_oe_rd, 0);
    chk("R9", "oe while idle", v_oe_idle, 0);
    chk("R8", "oe dropped during write strobe", oe_low_bad, 0);
    chk("R1", "rs changes inside cs", v_rs, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * CLK_NS);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule